// File: doc/BRIEF.md
# Buffer-Driven Test Packet Generator

This block produces framed streaming test packets whose payload is read from an external waveform buffer. It presents an address and a read strobe to the buffer, takes back the read data with a read-valid strobe one cycle later, and forwards each word on a stream output carrying valid, start and end of packet, a sync flag and a 64-bit block sequence number. Eight word registers choose the packet length, the idle gap between packets, the number of packets per sync group, an address window inside the buffer and the first sequence number.

Generation either starts straight away or waits, armed, for a pulse on an external sync input. The buffer address walks the window and wraps at its top without regard to packet edges, so one waveform longer or shorter than a packet streams out seamlessly. A downstream ready input gates whole packets: a packet whose first slot finds ready low is dropped, but the packet schedule and the sequence number keep running, so the stream re-enters on the same time grid with a sequence-number jump.

Top module: `tblk_gen`

## Requirements
- R1: After reset every register reads as zero and `out_valid` stays low.
- R2: Register word addresses: 0 control (bit 0 enable, bit 1 arm), 1 packet length, 2 packets per sync group, 3 gap length, 4 window low address, 5 window high address, 6 and 7 the low and high 32 bits of the first sequence number. Fields 1 to 3 are 16 bits, 4 and 5 are AW bits, 6 and 7 are 32 bits; a read returns the last written field value zero-extended. Control value 2 (arm without enable) produces no output.
- R3: Writing control value 1 from idle starts a packet whose first word is seen three clock edges after the register write edge. Writing 3 arms the block: nothing is emitted until `sync_in` is sampled high, and the first word is seen two edges after that sampling edge.
- R4: The read address starts at the low address, steps by one per emitted word, and returns to the low address after the high address, independently of packet edges; it does not advance for dropped packets.
- R5: Each emitted packet holds exactly length words on consecutive cycles, `out_sop` on the first and `out_eop` on the last.
- R6: The sequence number of the first packet after a start equals the programmed initial value and advances by one per packet period (including across the 32-bit boundary); it is valid with `out_sop`.
- R7: Consecutive packet starts are exactly length plus gap cycles apart; gap 0 gives back-to-back packets.
- R8: `out_sync` is high on a packet whose period index since start is a multiple of the packets-per-sync value.
- R9: Ready is sampled in a packet's first slot; if low, the whole packet is dropped while timing and numbering continue; a packet already started completes.
- R10: `out_valid` follows `buf_rdval` in the same cycle and `out_data` is `buf_rdata`, the buffer having one cycle of read latency.
- R11: Changes to length, gap, window or group size while running apply from the next packet boundary; no packet is truncated.
- R12: Clearing enable mid-packet finishes that packet then goes idle; a later enable restarts from the low address, the initial sequence number and a new sync group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| sync_in | input | 1 | External sync pulse for armed start |
| buf_addr | output | AW | Buffer read address |
| buf_rd | output | 1 | Buffer read enable |
| buf_rdata | input | DW | Buffer read data |
| buf_rdval | input | 1 | Buffer read-valid strobe |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | First word of packet |
| out_eop | output | 1 | Last word of packet |
| out_sync | output | 1 | Packet opens a sync group |
| out_bsn | output | 64 | Block sequence number |
| out_data | output | DW | Output sample word |

## Verification
The assertions take the buffer to be a plain one-cycle memory: `buf_rdval` rises only in the cycle after `buf_rd`, and never on its own. The bench's buffer model registers the read strobe and a computed data pattern, so this always holds. Ready is only ever changed between clock edges, and register writes that alter the window or length while running keep the high address at or above the low address, so address wrap checks stay well defined.

// File: rtl/tblk_pkg.sv
package tblk_pkg;
  localparam int CNT_W = 16;
  localparam int BSN_W = 64;
  localparam int REG_W = 32;
  localparam int RA_W  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_PKT, ST_GAP} seq_st_t;

  typedef struct packed {
    logic             en;
    logic             arm;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] bps;
    logic [CNT_W-1:0] gap;
    logic [BSN_W-1:0] bsn0;
  } gen_cfg_t;

  typedef struct packed {
    logic             sop;
    logic             eop;
    logic             sync;
    logic [BSN_W-1:0] bsn;
  } word_tag_t;
endpackage

// File: rtl/tblk_regs.sv
module tblk_regs
  import tblk_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [RA_W-1:0]  addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output gen_cfg_t         cfg,
  output logic [AW-1:0]    win_lo,
  output logic [AW-1:0]    win_hi
);
  localparam int NREG = 1 << RA_W;

  logic [NREG-1:0]  wsel;
  logic [1:0]       ctrl_q;
  logic [CNT_W-1:0] len_q, bps_q, gap_q;
  logic [AW-1:0]    lo_q, hi_q;
  logic [REG_W-1:0] bl_q, bh_q;

  always_comb begin
    wsel = '0;
    if (wr) wsel[addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      len_q  <= '0;
      bps_q  <= '0;
      gap_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      bl_q   <= '0;
      bh_q   <= '0;
    end else begin
      if (wsel[0]) ctrl_q <= wdata[1:0];
      if (wsel[1]) len_q  <= wdata[CNT_W-1:0];
      if (wsel[2]) bps_q  <= wdata[CNT_W-1:0];
      if (wsel[3]) gap_q  <= wdata[CNT_W-1:0];
      if (wsel[4]) lo_q   <= wdata[AW-1:0];
      if (wsel[5]) hi_q   <= wdata[AW-1:0];
      if (wsel[6]) bl_q   <= wdata;
      if (wsel[7]) bh_q   <= wdata;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = REG_W'(ctrl_q);
      3'd1:    rdata = REG_W'(len_q);
      3'd2:    rdata = REG_W'(bps_q);
      3'd3:    rdata = REG_W'(gap_q);
      3'd4:    rdata = REG_W'(lo_q);
      3'd5:    rdata = REG_W'(hi_q);
      3'd6:    rdata = bl_q;
      default: rdata = bh_q;
    endcase
  end

  assign cfg.en   = ctrl_q[0];
  assign cfg.arm  = ctrl_q[1];
  assign cfg.len  = len_q;
  assign cfg.bps  = bps_q;
  assign cfg.gap  = gap_q;
  assign cfg.bsn0 = {bh_q, bl_q};
  assign win_lo   = lo_q;
  assign win_hi   = hi_q;

  // R2: a write lands in the addressed register on the next edge
  p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd1) |=> (len_q == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/tblk_seq.sv
module tblk_seq
  import tblk_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  gen_cfg_t      cfg,
  input  logic [AW-1:0] win_lo,
  input  logic [AW-1:0] win_hi,
  input  logic          sync_in,
  input  logic          out_ready,
  output logic [AW-1:0] buf_addr,
  output logic          buf_rd,
  output word_tag_t     tag
);
  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] samp_q, samp_d, gapc_q, gapc_d, blk_q, blk_d;
  logic [CNT_W-1:0] len_q, len_d, gap_q, gap_d, bps_q, bps_d;
  logic [AW-1:0]    lo_q, lo_d, hi_q, hi_d, addr_q, addr_d, addr_nxt;
  logic [BSN_W-1:0] bsn_q, bsn_d;
  logic             emit_q, emit_d;
  logic             first_w, last_w, emit_w, fresh_w, cont_w;

  assign first_w  = (samp_q == '0);
  assign last_w   = ({1'b0, samp_q} + 1'b1) >= {1'b0, len_q};
  assign emit_w   = first_w ? out_ready : emit_q;
  assign buf_rd   = (st_q == ST_PKT) && emit_w;
  assign buf_addr = addr_q;
  assign addr_nxt = (addr_q >= hi_q) ? lo_q : addr_q + 1'b1;

  always_comb begin
    st_d    = st_q;
    samp_d  = samp_q;
    gapc_d  = gapc_q;
    blk_d   = blk_q;
    len_d   = len_q;
    gap_d   = gap_q;
    bps_d   = bps_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    addr_d  = addr_q;
    bsn_d   = bsn_q;
    emit_d  = emit_q;
    fresh_w = 1'b0;
    cont_w  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cfg.en) begin
          if (cfg.arm) st_d = ST_ARMED;
          else         fresh_w = 1'b1;
        end
      end
      ST_ARMED: begin
        if (!cfg.en)      st_d = ST_IDLE;
        else if (sync_in) fresh_w = 1'b1;
      end
      ST_PKT: begin
        if (first_w) emit_d = out_ready;
        if (buf_rd)  addr_d = addr_nxt;
        samp_d = samp_q + 1'b1;
        if (last_w) begin
          samp_d = '0;
          bsn_d  = bsn_q + 1'b1;
          blk_d  = (({1'b0, blk_q} + 1'b1) >= {1'b0, bps_q}) ? '0 : blk_q + 1'b1;
          if (gap_q == '0) begin
            if (cfg.en) cont_w = 1'b1;
            else        st_d = ST_IDLE;
          end else begin
            st_d   = ST_GAP;
            gapc_d = CNT_W'(1);
          end
        end
      end
      default: begin
        if (!cfg.en)               st_d = ST_IDLE;
        else if (gapc_q >= gap_q)  cont_w = 1'b1;
        else                       gapc_d = gapc_q + 1'b1;
      end
    endcase
    if (fresh_w || cont_w) begin
      st_d   = ST_PKT;
      samp_d = '0;
      len_d  = cfg.len;
      gap_d  = cfg.gap;
      bps_d  = cfg.bps;
      lo_d   = win_lo;
      hi_d   = win_hi;
    end
    if (fresh_w) begin
      bsn_d  = cfg.bsn0;
      blk_d  = '0;
      addr_d = win_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      samp_q <= '0;
      gapc_q <= '0;
      blk_q  <= '0;
      len_q  <= '0;
      gap_q  <= '0;
      bps_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      addr_q <= '0;
      bsn_q  <= '0;
      emit_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      samp_q <= samp_d;
      gapc_q <= gapc_d;
      blk_q  <= blk_d;
      len_q  <= len_d;
      gap_q  <= gap_d;
      bps_q  <= bps_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      addr_q <= addr_d;
      bsn_q  <= bsn_d;
      emit_q <= emit_d;
    end
  end

  assign tag.sop  = first_w;
  assign tag.eop  = last_w;
  assign tag.sync = (blk_q == '0);
  assign tag.bsn  = bsn_q;

  // R3: an armed generator issues no read until sync arrives
  p_armed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && !sync_in) |=> !buf_rd);

  // R11 / R12: a packet in flight is never cut short
  p_no_trunc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PKT && !last_w) |=> (st_q == ST_PKT));

  // R6: sequence number steps by one at each packet end
  p_bsn_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PKT && last_w) |=> (bsn_q == $past(bsn_q) + BSN_W'(1)));
endmodule

// File: rtl/tblk_tagpipe.sv
module tblk_tagpipe
  import tblk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_rd,
  input  word_tag_t        tag_in,
  input  logic             buf_rdval,
  output logic             out_valid,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_sync,
  output logic [BSN_W-1:0] out_bsn
);
  logic      pend_q;
  word_tag_t tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tag_q  <= '0;
    end else begin
      pend_q <= buf_rd;
      if (buf_rd) tag_q <= tag_in;
    end
  end

  assign out_valid = buf_rdval & pend_q;
  assign out_sop   = out_valid & tag_q.sop;
  assign out_eop   = out_valid & tag_q.eop;
  assign out_sync  = out_valid & tag_q.sync;
  assign out_bsn   = tag_q.bsn;

  // R10: the buffer answers exactly one cycle after a read
  p_rdval_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rdval |-> $past(buf_rd));
endmodule

// File: rtl/tblk_gen.sv
module tblk_gen
  import tblk_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sync_in,
  output logic [AW-1:0]    buf_addr,
  output logic             buf_rd,
  input  logic [DW-1:0]    buf_rdata,
  input  logic             buf_rdval,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_sync,
  output logic [BSN_W-1:0] out_bsn,
  output logic [DW-1:0]    out_data
);
  gen_cfg_t  cfg;
  word_tag_t tag;
  logic [AW-1:0] win_lo, win_hi;

  tblk_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg),
    .win_lo(win_lo), .win_hi(win_hi)
  );

  tblk_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .win_lo(win_lo), .win_hi(win_hi),
    .sync_in(sync_in), .out_ready(out_ready),
    .buf_addr(buf_addr), .buf_rd(buf_rd), .tag(tag)
  );

  tblk_tagpipe pipe_i (
    .clk(clk), .rst_n(rst_n), .buf_rd(buf_rd), .tag_in(tag),
    .buf_rdval(buf_rdval), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_sync(out_sync), .out_bsn(out_bsn)
  );

  assign out_data = buf_rdata;

  // R9: a packet only begins if ready was high in its first slot
  p_sop_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> $past(out_ready));
endmodule

// File: tb/tblk_gen_tb_top.sv
module tblk_gen_tb_top;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int CAP = 2048;

  logic clk, rst_n, reg_wr, sync_in, out_ready;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [AW-1:0] buf_addr;
  logic buf_rd, buf_rdval;
  logic [DW-1:0] buf_rdata, out_data;
  logic out_valid, out_sop, out_eop, out_sync;
  logic [63:0] out_bsn;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int cap_n = 0;
  logic [DW-1:0] cap_d [CAP];
  logic          cap_s [CAP];
  logic          cap_e [CAP];
  logic          cap_y [CAP];
  logic [63:0]   cap_b [CAP];
  int            cap_c [CAP];

  tblk_gen #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_in(sync_in),
    .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
    .buf_rdval(buf_rdval), .out_ready(out_ready), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_sync(out_sync),
    .out_bsn(out_bsn), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DW-1:0] fpat(input int a);
    return DW'(a * 37 + 5);
  endfunction

  // one-cycle-latency buffer model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_rdval <= 1'b0;
      buf_rdata <= '0;
    end else begin
      buf_rdval <= buf_rd;
      if (buf_rd) buf_rdata <= fpat(int'(buf_addr));
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && cap_n < CAP) begin
      cap_d[cap_n] = out_data;
      cap_s[cap_n] = out_sop;
      cap_e[cap_n] = out_eop;
      cap_y[cap_n] = out_sync;
      cap_b[cap_n] = out_bsn;
      cap_c[cap_n] = cyc;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d, output int c);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
    c = cyc;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int len, bps, gap, lo, hi, input logic [63:0] b0);
    int c;
    wr_reg(1, len, c); wr_reg(2, bps, c); wr_reg(3, gap, c);
    wr_reg(4, lo, c);  wr_reg(5, hi, c);
    wr_reg(6, int'(b0[31:0]), c); wr_reg(7, int'(b0[63:32]), c);
  endtask

  // framing, data walk, numbering, period and sync over the whole capture
  task automatic check_run(input int len, gap, lo, hi, bps, input logic [63:0] b0, input bit thr);
    int w, p, npk, slots, base;
    bit ok5, ok4;
    w = hi - lo + 1;
    p = len + gap;
    chk(cap_n > 0 && cap_n % len == 0, "R5 word count multiple of length", cap_n, len);
    npk = cap_n / len;
    for (int k = 0; k < npk; k++) begin
      base = k * len;
      ok5 = 1'b1; ok4 = 1'b1;
      for (int i = 0; i < len; i++) begin
        if (cap_s[base+i] != (i == 0) || cap_e[base+i] != (i == len-1) ||
            cap_c[base+i] != cap_c[base] + i) ok5 = 1'b0;
        if (cap_d[base+i] != fpat(lo + (base + i) % w)) ok4 = 1'b0;
      end
      chk(ok5, "R5 packet framing", k, k);
      chk(ok4, "R4 R10 data walk", cap_d[base], fpat(lo + base % w));
      slots = (cap_c[base] - cap_c[0]) / p;
      chk((cap_c[base] - cap_c[0]) % p == 0, "R7 start on period grid", cap_c[base] - cap_c[0], slots * p);
      if (!thr) chk(slots == k, "R7 packet spacing", slots, k);
      chk(cap_b[base] == b0 + 64'(slots), "R6 sequence number", longint'(cap_b[base]), longint'(b0 + 64'(slots)));
      chk(cap_y[base] == (slots % bps == 0), "R8 sync flag", cap_y[base], slots % bps == 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int c, c0, drop, rise, skips, lastlen, bad, st;
    logic [63:0] b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    sync_in = 1'b0; out_ready = 1'b1;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_reg(a, rv);
      chk(rv == 0, "R1 register reset", rv, 0);
    end
    chk(out_valid == 1'b0 && cap_n == 0, "R1 no output after reset", cap_n, 0);

    // R2 readback of every field
    setup(6, 3, 2, 2, 6, 64'h1_FFFF_FFFE);
    wr_reg(0, 2, c);
    idle(20);
    chk(cap_n == 0, "R2 arm without enable emits nothing", cap_n, 0);
    begin
      int exp_v [8] = '{2, 6, 3, 2, 2, 6, 32'hFFFF_FFFE, 1};
      for (int a = 0; a < 8; a++) begin
        rd_reg(a, rv);
        chk(rv == 32'(exp_v[a]), "R2 register readback", rv, exp_v[a]);
      end
    end

    // run 1: gap, window not dividing the length, sequence crosses 32 bits
    b0 = 64'h1_FFFF_FFFE;
    cap_n = 0;
    wr_reg(0, 1, c0);
    idle(100);
    chk(cap_c[0] == c0 + 3, "R3 immediate start latency", cap_c[0], c0 + 3);
    wr_reg(0, 0, c);
    idle(30);
    check_run(6, 2, 2, 6, 3, b0, 1'b0);

    // run 2: no gap, full window, disable mid-packet then restart
    setup(5, 4, 0, 0, 31, 64'd100);
    cap_n = 0;
    wr_reg(0, 1, c);
    idle(40);
    while (!(out_valid && out_sop)) @(negedge clk);
    idle(1);
    wr_reg(0, 0, c);
    idle(30);
    st = cap_n;
    chk(cap_n % 5 == 0 && cap_e[cap_n-1], "R12 disable completes packet", cap_n % 5, 0);
    idle(20);
    chk(cap_n == st, "R12 idle after disable", cap_n, st);
    check_run(5, 0, 0, 31, 4, 64'd100, 1'b0);
    cap_n = 0;
    wr_reg(0, 1, c);
    idle(30);
    wr_reg(0, 0, c);
    idle(20);
    chk(cap_b[0] == 64'd100 && cap_y[0] && cap_d[0] == fpat(0), "R12 restart from initial state",
        longint'(cap_b[0]), 100);
    check_run(5, 0, 0, 31, 4, 64'd100, 1'b0);

    // run 3: armed start on the external pulse
    setup(4, 2, 3, 3, 10, 64'd9);
    cap_n = 0;
    wr_reg(0, 3, c);
    idle(30);
    chk(cap_n == 0, "R3 armed waits for sync", cap_n, 0);
    @(negedge clk);
    sync_in = 1'b1; c0 = cyc;
    @(negedge clk);
    sync_in = 1'b0;
    idle(60);
    chk(cap_n > 0 && cap_c[0] == c0 + 2, "R3 sync start latency", cap_c[0], c0 + 2);
    wr_reg(0, 0, c);
    idle(30);
    check_run(4, 3, 3, 10, 2, 64'd9, 1'b0);

    // run 4: throttling by ready
    setup(4, 5, 2, 1, 9, 64'd7);
    cap_n = 0;
    wr_reg(0, 1, c);
    idle(40);
    @(negedge clk); out_ready = 1'b0; drop = cyc;
    idle(50);
    @(negedge clk); out_ready = 1'b1; rise = cyc;
    idle(60);
    wr_reg(0, 0, c);
    idle(30);
    check_run(4, 2, 1, 9, 5, 64'd7, 1'b1);
    skips = 0; bad = 0;
    for (int n = 0; n < cap_n; n++) begin
      if (cap_s[n] && cap_c[n] >= drop + 1 && cap_c[n] <= rise) bad++;
      if (cap_s[n] && n >= 4 && cap_b[n] > cap_b[n-4] + 64'd1) skips++;
    end
    chk(bad == 0, "R9 no packet starts while ready low", bad, 0);
    chk(skips > 0, "R9 sequence jumps after throttle", skips, 1);

    // run 5: length changed while running
    setup(4, 3, 1, 0, 15, 64'd0);
    out_ready = 1'b1;
    cap_n = 0;
    wr_reg(0, 1, c);
    idle(27);
    wr_reg(1, 7, c);
    idle(60);
    wr_reg(0, 0, c);
    idle(30);
    bad = 0; lastlen = 0; st = 0;
    for (int n = 0; n < cap_n; n++) begin
      if (cap_s[n]) st = n;
      if (cap_e[n]) begin
        if (!(n - st + 1 == 4 || n - st + 1 == 7)) bad++;
        if (lastlen == 7 && n - st + 1 == 4) bad++;
        lastlen = n - st + 1;
      end
    end
    chk(bad == 0, "R11 packets whole and change at a boundary", bad, 0);
    chk(lastlen == 7, "R11 new length in effect", lastlen, 7);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule